// File: doc/BRIEF.md
# Memory-Type-Tagged L1 Data Cache Controller

This block is a small direct-mapped, write-through first-level data cache. It sits between one core request port and two downstream ports, a second-level cache port and a direct memory port, plus a write-combine output.

Every core access carries a one-bit memory type taken from the page table entry. The cache stores that bit with each line it fills. The bit only matters when a request misses and when the bulk invalidate command arrives:

- On a read miss, it picks the port that supplies the line.
- On a write miss, it picks where the write goes.
- The invalidate command drops, in a single cycle, every line stored with the bit set and leaves the other lines untouched.

The type of a given address may differ from one access to the next. Hits ignore the request's type.

The data array has one synchronous read port and one write port, so block RAM can hold it. The valid, type and tag bits sit in flops so that they can all be cleared in parallel. An accepted request is looked up in the following cycle. A read miss holds the core port not-ready until the chosen downstream port returns the line. Writes never allocate a line.

Top module: `mtl1_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `inv_done`, `l2_req_valid`, `mem_req_valid` and `wc_valid` are 0. Every line is invalid, so the first read of any address misses.
- R2: A read miss whose request type bit is 1 pulses `mem_req_valid` for one cycle with `mem_req_addr` set to the line base (address bits [4:0] cleared), and leaves the L2 port idle. While the cache waits for that line, a pulse on `l2_rsp_valid` is ignored.
- R3: A read miss whose request type bit is 0 pulses `l2_req_valid` with `l2_req_we`=0 and `l2_req_addr` set to the line base, and leaves the memory port idle. While the cache waits for that line, a pulse on `mem_rsp_valid` is ignored.
- R4: A read miss holds `req_ready` at 0 from the cycle after acceptance until the line arrives. In the cycle after the selected port's response, `rsp_valid` is 1 and `rsp_rdata` holds word bits [4:2] of the returned line, where word w is line bits [32w+31:32w]. `req_ready` is 1 again in that same cycle.
- R5: A request accepted at one clock edge is looked up at the next edge. A read hit then shows `rsp_valid`=1 with the cached word and issues no downstream request, whatever the request's type bit is.
- R6: A write hit updates the cached word and is forwarded on the L2 port (`l2_req_we`=1, full address, data) for either type bit. `wc_valid` stays 0.
- R7: A write miss is forwarded on the write-combine port (`wc_valid`, `wc_addr`, `wc_wdata`) when its type bit is 1, and on the L2 port as a write when the bit is 0. No line is allocated, so a later read of that address misses.
- R8: A one-cycle `inv_cmd` makes invalid every line whose stored type bit is 1. Lines stored with type 0 keep hitting with their data. `inv_done` is 1 in the cycle after the command.
- R9: A line's stored type is the type bit of the read miss that filled it. Later hits and write hits with the other type bit neither change it nor cause a miss.
- R10: Address fields are fixed: index is bits [10:5] and tag is bits [31:11]. Two addresses with equal index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write data |
| req_mt | input | 1 | Memory-type bit from the page table entry |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | WORD_W | Read data |
| inv_cmd | input | 1 | Invalidate all lines stored with type bit 1 |
| inv_done | output | 1 | Pulse in the cycle after `inv_cmd` |
| l2_req_valid | output | 1 | L2 port request pulse |
| l2_req_we | output | 1 | L2 request is a write |
| l2_req_addr | output | ADDR_W | L2 request address (line base for reads) |
| l2_req_wdata | output | WORD_W | L2 write data |
| l2_rsp_valid | input | 1 | L2 line return |
| l2_rsp_line | input | LINE_BYTES*8 | Line returned by L2 |
| mem_req_valid | output | 1 | Memory port line fetch pulse |
| mem_req_addr | output | ADDR_W | Line base address for the fetch |
| mem_rsp_valid | input | 1 | Memory line return |
| mem_rsp_line | input | LINE_BYTES*8 | Line returned by memory |
| wc_valid | output | 1 | Write-combine write pulse |
| wc_addr | output | ADDR_W | Write-combine address |
| wc_wdata | output | WORD_W | Write-combine data |

## Verification
Directed sequences come first. They flip the type bit on the same address between fill and hit, which separates per-line stored type from per-request type. They issue tagged and untagged write misses to show routing and no-allocate. They invalidate a mix of tagged and untagged lines and then read both kinds back. They also inject a response on the port that was not selected, which shows that only the chosen fill path is listened to.

After that, a seeded random mix of reads, writes and invalidates runs over a few tags that collide on the same indices. This exercises hits, evictions and type changes in orders the directed part does not reach. Each result is compared with a model of line state kept in the bench.

// File: rtl/mtl1_pkg.sv
package mtl1_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } mtl1_state_e;

endpackage

// File: rtl/mtl1_tag_store.sv
module mtl1_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 21
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] look_idx,
  output logic                     look_valid,
  output logic [TAG_W-1:0]         look_tag,
  input  logic                     fill_en,
  input  logic [$clog2(LINES)-1:0] fill_idx,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     fill_mt,
  input  logic                     inv_en
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] mt_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // Valid and type live in flops so that the tagged invalidate can clear them all at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      mt_q    <= '0;
    end else begin
      if (inv_en) valid_q <= valid_q & ~mt_q;
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        mt_q[fill_idx]    <= fill_mt;
      end
    end
  end

  // Tags need no reset: a tag is only compared when its valid bit is set.
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign look_valid = valid_q[look_idx];
  assign look_tag   = tag_q[look_idx];

  // R8
  inv_clears_tagged_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !fill_en) |=> ((valid_q & mt_q) == '0));

  // R4
  fill_installs_line_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q[$past(fill_idx)] && (mt_q[$past(fill_idx)] == $past(fill_mt))));

  // R9
  mt_only_changes_on_fill_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> $stable(mt_q));

  logic [IDX_W-1:0] unused_idx_w;
  assign unused_idx_w = '0;
endmodule

// File: rtl/mtl1_line_ram.sv
module mtl1_line_ram #(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 256
) (
  input  logic                     clk,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [LINE_W-1:0]        rdata,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [LINE_W-1:0]        wdata
);
  logic [LINE_W-1:0] mem [DEPTH];

  // One write port and one registered read port, a shape that maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtl1_cache.sv
module mtl1_cache
  import mtl1_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic                    req_mt,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata,
  input  logic                    inv_cmd,
  output logic                    inv_done,
  output logic                    l2_req_valid,
  output logic                    l2_req_we,
  output logic [ADDR_W-1:0]       l2_req_addr,
  output logic [WORD_W-1:0]       l2_req_wdata,
  input  logic                    l2_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] l2_rsp_line,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_line,
  output logic                    wc_valid,
  output logic [ADDR_W-1:0]       wc_addr,
  output logic [WORD_W-1:0]       wc_wdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BOFF_W = $clog2(WORD_W / 8);

  mtl1_state_e state_q;

  logic              p_we;
  logic              p_mt;
  logic [ADDR_W-1:0] p_addr;
  logic [WORD_W-1:0] p_wdata;

  logic [IDX_W-1:0]  p_idx;
  logic [TAG_W-1:0]  p_tag;
  logic [WSEL_W-1:0] p_wsel;
  logic [ADDR_W-1:0] line_base;

  logic              ts_valid;
  logic [TAG_W-1:0]  ts_tag;
  logic              hit;

  logic              accept;
  logic              in_look;
  logic              in_fill;
  logic              fill_got;
  logic [LINE_W-1:0] fill_line;
  logic [LINE_W-1:0] ram_q;
  logic [LINE_W-1:0] merged_line;
  logic              ram_we;
  logic [LINE_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_word;
  logic [WORD_W-1:0] fill_word;

  // Address split: offset, index and tag.
  assign p_idx     = p_addr[OFF_W +: IDX_W];
  assign p_tag     = p_addr[ADDR_W-1 -: TAG_W];
  assign p_wsel    = p_addr[BOFF_W +: WSEL_W];
  assign line_base = {p_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign in_look   = (state_q == ST_LOOK);
  assign in_fill   = (state_q == ST_FILL);

  assign hit = ts_valid && (ts_tag == p_tag);

  // Only the port chosen by the request type may complete a fill.
  assign fill_got  = p_mt ? mem_rsp_valid : l2_rsp_valid;
  assign fill_line = p_mt ? mem_rsp_line  : l2_rsp_line;

  assign ram_word  = ram_q[p_wsel*WORD_W +: WORD_W];
  assign fill_word = fill_line[p_wsel*WORD_W +: WORD_W];

  // Write-hit merge: one lane takes the new word, the rest keep the line read at acceptance.
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    assign merged_line[w*WORD_W +: WORD_W] =
      (p_wsel == WSEL_W'(w)) ? p_wdata : ram_q[w*WORD_W +: WORD_W];
  end

  assign ram_we    = (in_look && p_we && hit) || (in_fill && fill_got);
  assign ram_wdata = in_fill ? fill_line : merged_line;

  mtl1_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk        (clk),
    .rst        (rst),
    .look_idx   (p_idx),
    .look_valid (ts_valid),
    .look_tag   (ts_tag),
    .fill_en    (in_fill && fill_got),
    .fill_idx   (p_idx),
    .fill_tag   (p_tag),
    .fill_mt    (p_mt),
    .inv_en     (inv_cmd)
  );

  mtl1_line_ram #(
    .DEPTH  (LINES),
    .LINE_W (LINE_W)
  ) u_data (
    .clk   (clk),
    .re    (accept),
    .raddr (req_addr[OFF_W +: IDX_W]),
    .rdata (ram_q),
    .we    (ram_we),
    .waddr (p_idx),
    .wdata (ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      p_we          <= 1'b0;
      p_mt          <= 1'b0;
      p_addr        <= '0;
      p_wdata       <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      inv_done      <= 1'b0;
      l2_req_valid  <= 1'b0;
      l2_req_we     <= 1'b0;
      l2_req_addr   <= '0;
      l2_req_wdata  <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      wc_valid      <= 1'b0;
      wc_addr       <= '0;
      wc_wdata      <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      l2_req_valid  <= 1'b0;
      mem_req_valid <= 1'b0;
      wc_valid      <= 1'b0;
      inv_done      <= inv_cmd;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            p_we    <= req_we;
            p_mt    <= req_mt;
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!p_we) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= ram_word;
              state_q   <= ST_IDLE;
            end else begin
              if (p_mt) begin
                mem_req_valid <= 1'b1;
                mem_req_addr  <= line_base;
              end else begin
                l2_req_valid <= 1'b1;
                l2_req_we    <= 1'b0;
                l2_req_addr  <= line_base;
              end
              state_q <= ST_FILL;
            end
          end else begin
            // Write-through: hits and untagged misses go to L2, tagged misses to write-combine.
            if (hit || !p_mt) begin
              l2_req_valid <= 1'b1;
              l2_req_we    <= 1'b1;
              l2_req_addr  <= p_addr;
              l2_req_wdata <= p_wdata;
            end else begin
              wc_valid <= 1'b1;
              wc_addr  <= p_addr;
              wc_wdata <= p_wdata;
            end
            state_q <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (fill_got) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= fill_word;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  one_downstream_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l2_req_valid, mem_req_valid, wc_valid}));

  // R4
  fetch_stalls_core_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || (l2_req_valid && !l2_req_we)) |-> !req_ready);

  // R5
  rsp_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && !l2_req_valid && !mem_req_valid));

  // R8
  inv_done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inv_cmd |=> inv_done);

  // R7
  wc_only_for_writes_chk: assert property (@(posedge clk) disable iff (rst)
    wc_valid |-> (!rsp_valid && req_ready));
endmodule

// File: tb/tb_mtl1_cache.sv
module tb_mtl1_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         req_valid = 0, req_we = 0, req_mt = 0;
  logic [31:0]  req_addr = 0, req_wdata = 0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         inv_cmd = 0, inv_done;
  logic         l2_req_valid, l2_req_we;
  logic [31:0]  l2_req_addr, l2_req_wdata;
  logic         l2_rsp_valid = 0;
  logic [255:0] l2_rsp_line = '0;
  logic         mem_req_valid;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 0;
  logic [255:0] mem_rsp_line = '0;
  logic         wc_valid;
  logic [31:0]  wc_addr, wc_wdata;

  mtl1_cache dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mt(req_mt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .inv_cmd(inv_cmd), .inv_done(inv_done),
    .l2_req_valid(l2_req_valid), .l2_req_we(l2_req_we),
    .l2_req_addr(l2_req_addr), .l2_req_wdata(l2_req_wdata),
    .l2_rsp_valid(l2_rsp_valid), .l2_rsp_line(l2_rsp_line),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
    .wc_valid(wc_valid), .wc_addr(wc_addr), .wc_wdata(wc_wdata)
  );

  int total = 0;
  int bad   = 0;

  // Bench model of the cache state and of the backing store.
  bit          m_valid [64];
  bit          m_mt    [64];
  logic [20:0] m_tag   [64];
  logic [31:0] m_data  [64][8];
  logic [31:0] bk [bit [31:0]];

  function automatic logic [31:0] bk_word(input logic [31:0] a);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    if (bk.exists(wa)) return bk[wa];
    return {wa[15:0] ^ 16'hA5C3, wa[31:16] ^ wa[15:0]};
  endfunction

  function automatic logic [255:0] bk_line(input logic [31:0] base);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = bk_word(base + 32'(w*4));
    return l;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input bit mt, input bit junk);
    logic [5:0]   idx;
    logic [20:0]  tg;
    logic [2:0]   ws;
    logic [31:0]  base;
    logic [255:0] line;
    bit           hit;
    idx  = addr[10:5];
    tg   = addr[31:11];
    ws   = addr[4:2];
    base = {addr[31:5], 5'b0};
    hit  = m_valid[idx] && (m_tag[idx] == tg);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = addr; req_wdata = wd; req_mt = mt;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R4 not ready during lookup", 256'(req_ready), 0);
    @(negedge clk);
    if (!we) begin
      if (hit) begin
        chk(rsp_valid == 1, "R5 hit response", 256'(rsp_valid), 1);
        chk(rsp_rdata == m_data[idx][ws], "R5/R9 hit data", 256'(rsp_rdata), 256'(m_data[idx][ws]));
        chk(!l2_req_valid && !mem_req_valid, "R5 hit no downstream", 256'({l2_req_valid, mem_req_valid}), 0);
      end else begin
        if (mt) begin
          chk(mem_req_valid && !l2_req_valid, "R2 tagged miss to mem", 256'({mem_req_valid, l2_req_valid}), 2);
          chk(mem_req_addr == base, "R2 fetch address", 256'(mem_req_addr), 256'(base));
        end else begin
          chk(l2_req_valid && !l2_req_we && !mem_req_valid, "R3 untagged miss to L2",
              256'({l2_req_valid, l2_req_we, mem_req_valid}), 4);
          chk(l2_req_addr == base, "R3 fetch address", 256'(l2_req_addr), 256'(base));
        end
        chk(rsp_valid == 0 && req_ready == 0, "R4 stall on miss", 256'({rsp_valid, req_ready}), 0);
        if (junk) begin
          if (mt) begin l2_rsp_valid = 1; l2_rsp_line = ~bk_line(base); end
          else    begin mem_rsp_valid = 1; mem_rsp_line = ~bk_line(base); end
          @(negedge clk);
          l2_rsp_valid = 0; mem_rsp_valid = 0;
          chk(rsp_valid == 0 && req_ready == 0, mt ? "R2 L2 reply ignored" : "R3 mem reply ignored",
              256'({rsp_valid, req_ready}), 0);
        end
        line = bk_line(base);
        if (mt) begin mem_rsp_valid = 1; mem_rsp_line = line; end
        else    begin l2_rsp_valid = 1; l2_rsp_line = line; end
        @(negedge clk);
        l2_rsp_valid = 0; mem_rsp_valid = 0;
        chk(rsp_valid == 1 && req_ready == 1, "R4 fill response", 256'({rsp_valid, req_ready}), 3);
        chk(rsp_rdata == line[ws*32 +: 32], "R4 fill data", 256'(rsp_rdata), 256'(line[ws*32 +: 32]));
        m_valid[idx] = 1; m_mt[idx] = mt; m_tag[idx] = tg;
        for (int w = 0; w < 8; w++) m_data[idx][w] = line[w*32 +: 32];
      end
    end else begin
      if (hit) begin
        chk(l2_req_valid && l2_req_we && !wc_valid, "R6 write hit to L2",
            256'({l2_req_valid, l2_req_we, wc_valid}), 6);
        chk(l2_req_addr == addr && l2_req_wdata == wd, "R6 write hit payload",
            {l2_req_addr, l2_req_wdata}, {addr, wd});
        m_data[idx][ws] = wd;
      end else if (mt) begin
        chk(wc_valid && !l2_req_valid, "R7 tagged write miss to wc", 256'({wc_valid, l2_req_valid}), 2);
        chk(wc_addr == addr && wc_wdata == wd, "R7 wc payload", {wc_addr, wc_wdata}, {addr, wd});
      end else begin
        chk(l2_req_valid && l2_req_we && !wc_valid, "R7 untagged write miss to L2",
            256'({l2_req_valid, l2_req_we, wc_valid}), 6);
        chk(l2_req_addr == addr && l2_req_wdata == wd, "R7 L2 write payload",
            {l2_req_addr, l2_req_wdata}, {addr, wd});
      end
      bk[{addr[31:2], 2'b00}] = wd;
      chk(req_ready == 1 && rsp_valid == 0, "R6/R7 write returns idle", 256'({req_ready, rsp_valid}), 2);
    end
  endtask

  task automatic invalidate();
    @(negedge clk);
    inv_cmd = 1;
    @(negedge clk);
    inv_cmd = 0;
    chk(inv_done == 1, "R8 inv_done pulse", 256'(inv_done), 1);
    for (int i = 0; i < 64; i++) if (m_mt[i]) m_valid[i] = 0;
    @(negedge clk);
    chk(inv_done == 0, "R8 inv_done one cycle", 256'(inv_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a_lo, b_tg, c_wm, d_wm, e_ev;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin m_valid[i] = 0; m_mt[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready after reset", 256'(req_ready), 1);
    chk(!rsp_valid && !inv_done, "R1 rsp/inv idle", 256'({rsp_valid, inv_done}), 0);
    chk(!l2_req_valid && !mem_req_valid && !wc_valid, "R1 ports idle",
        256'({l2_req_valid, mem_req_valid, wc_valid}), 0);

    a_lo = 32'h0000_1824;   // index 1
    b_tg = 32'h0003_0048;   // index 2
    c_wm = 32'h0005_00C4;   // index 6
    d_wm = 32'h0007_00E8;   // index 7
    e_ev = 32'h0009_1824;   // index 1, other tag (R10)

    access(0, a_lo, 0, 0, 1);            // R1 first read misses, R3 path
    access(0, a_lo, 0, 1, 0);            // R9 hit with the other type
    access(0, b_tg, 0, 1, 1);            // R2 path
    access(1, b_tg, 32'hDEAD_BEEF, 0, 0);// R6 write hit, untagged request
    access(0, b_tg, 0, 0, 0);            // R6 updated data
    access(1, c_wm, 32'h1111_2222, 1, 0);// R7 tagged write miss
    access(1, d_wm, 32'h3333_4444, 0, 0);// R7 untagged write miss
    access(0, c_wm, 0, 0, 0);            // R7 no allocate
    invalidate();                        // R8
    access(0, a_lo, 0, 1, 0);            // R8 untagged line kept
    access(0, b_tg, 0, 0, 0);            // R8 tagged line gone
    access(0, e_ev, 0, 0, 0);            // R10 eviction
    access(0, a_lo, 0, 0, 0);            // R10 evicted line misses

    for (int n = 0; n < 500; n++) begin
      int unsigned r;
      logic [31:0] ad;
      r  = $urandom_range(0, 99);
      ad = {$urandom_range(0, 3) == 0 ? 21'h15 : 21'($urandom_range(0, 2)),
            6'($urandom_range(0, 11)), 3'($urandom_range(0, 7)), 2'b00};
      if (r < 8) invalidate();
      else if (r < 40) access(1, ad, $urandom, 1'($urandom_range(0, 1)), 0);
      else access(0, ad, 0, 1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule